// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two 4x4 matrices of signed 8-bit numbers on a square mesh of sixteen multiply-accumulate cells. Each product element stays inside its own cell for the whole computation. Operands move between neighbouring cells only. Left-hand operands travel rightward along the rows of the mesh and right-hand operands travel downward along its columns. Both matrices enter with a diagonal stagger, so the two factors of each partial product reach the same cell in the same cycle.

To use the block, software or an upstream engine first writes the left matrix and the right matrix into two small operand stores. It then pulses `start`. The sequencer clears every accumulator, steps through the staggered feed, and raises `done` once every cell has absorbed its last partial product. After that, any element of the result can be read through an indexed port that has one cycle of latency.

Top module: `mm_top`

## Requirements
- R1: After reset, `busy` and `done` are low and every result element reads back as 0.
- R2: A write to the left store places the value at row `a_wr_addr[3:2]`, column `a_wr_addr[1:0]`. A write to the right store places it at row `b_wr_addr[3:2]`, column `b_wr_addr[1:0]`. Each write takes effect on the clock edge where its enable is high while `busy` is low.
- R3: A `start` sampled while idle clears all sixteen accumulators, and `busy` is high in the next cycle.
- R4: `busy` stays high for exactly 10 cycles. On the 10th clock edge after the edge that accepted `start`, `busy` falls and `done` rises. `busy` and `done` are never both high.
- R5: When `done` is high, the element at row i, column j equals the exact signed sum over k of A[i][k]·B[k][j].
- R6: `rd_data` presents, sign-extended to 20 bits, the element whose row is `rd_addr[3:2]` and whose column is `rd_addr[1:0]`, one clock after `rd_addr` is sampled.
- R7: `done` stays high until the next accepted `start`, and it is low in the cycle after that start.
- R8: A `start` sampled while `busy` is high is ignored. The run length and the results are unchanged.
- R9: Operand writes attempted while `busy` is high are ignored. The stores keep their contents.
- R10: The operand stores keep their contents across runs, so a second `start` with no new writes reproduces the same results.
- R11: The accumulation is exact at the operand extremes: all -128 times all -128 gives 65536, and all 127 times all -128 gives -65024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| a_wr_en | input | 1 | Write enable for the left-operand store |
| a_wr_addr | input | 4 | Left store index {row, column} |
| a_wr_data | input | 8 | Signed left operand |
| b_wr_en | input | 1 | Write enable for the right-operand store |
| b_wr_addr | input | 4 | Right store index {row, column} |
| b_wr_data | input | 8 | Signed right operand |
| rd_addr | input | 4 | Result index {row, column} |
| busy | output | 1 | Operands are flowing through the mesh |
| done | output | 1 | All results are complete |
| rd_data | output | 20 | Signed result element, registered |

## Verification
A stagger that is off by one in a row or a column pairs the wrong values of k inside the cells. That error shows up only as wrong sums at the read port, after `done`, and it appears in whole rows or columns of the result. Matrices with distinct entries expose it, whereas an identity matrix or a constant matrix can hide it. A miscounted sequencer shows up much sooner, as `busy` or `done` changing on the wrong edge within the first 11 cycles after `start`. Stray accumulation or a missing clear shows up as results that differ between two back-to-back runs on the same operands.

// File: rtl/mm_pkg.sv
package mm_pkg;

  localparam int MM_DIM  = 4;
  localparam int MM_OPW  = 8;
  localparam int MM_ACCW = 20;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mm_state_e;

  // feed steps needed for an n x n mesh: 2n-1 wavefronts plus n-1 drain
  function automatic int run_cycles(input int n);
    return 3 * n - 2;
  endfunction

endpackage

// File: rtl/mm_opbuf.sv
module mm_opbuf #(
  parameter int N   = mm_pkg::MM_DIM,
  parameter int OPW = mm_pkg::MM_OPW,
  localparam int IW = $clog2(N * N)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_addr,
  input  logic signed [OPW-1:0] wr_data,
  output logic signed [OPW-1:0] mem [N*N]
);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
  parameter int N    = mm_pkg::MM_DIM,
  localparam int RUN = mm_pkg::run_cycles(N),
  localparam int CW  = $clog2(RUN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          clr,
  output logic          run,
  output logic [CW-1:0] step,
  output logic          done
);

  import mm_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  mm_state_e state;

  assign clr = start && (state == ST_IDLE);
  assign run = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            step  <= '0;
            done  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (step == LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mm_skew.sv
module mm_skew #(
  parameter int N   = mm_pkg::MM_DIM,
  parameter int OPW = mm_pkg::MM_OPW,
  parameter int CW  = 4,
  localparam int IW = $clog2(N * N)
) (
  input  logic                  run,
  input  logic [CW-1:0]         step,
  input  logic signed [OPW-1:0] abuf [N*N],
  input  logic signed [OPW-1:0] bbuf [N*N],
  output logic signed [OPW-1:0] a_edge [N],
  output logic signed [OPW-1:0] b_edge [N]
);

  // lane e receives element k = step - e; out-of-range slots are zero bubbles
  always_comb begin
    for (int e = 0; e < N; e++) begin
      a_edge[e] = '0;
      b_edge[e] = '0;
      if (run && (int'(step) >= e) && (int'(step) - e < N)) begin
        a_edge[e] = abuf[IW'(e * N + int'(step) - e)];
        b_edge[e] = bbuf[IW'((int'(step) - e) * N + e)];
      end
    end
  end

endmodule

// File: rtl/mm_cell.sv
module mm_cell #(
  parameter int OPW  = mm_pkg::MM_OPW,
  parameter int ACCW = mm_pkg::MM_ACCW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [OPW-1:0]  a_in,
  input  logic signed [OPW-1:0]  b_in,
  output logic signed [ACCW-1:0] acc
);

  logic signed [2*OPW-1:0] prod;

  assign prod = a_in * b_in;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (en) begin
      acc <= acc + ACCW'(prod);
    end
  end

endmodule

// File: rtl/mm_grid.sv
module mm_grid #(
  parameter int N    = mm_pkg::MM_DIM,
  parameter int OPW  = mm_pkg::MM_OPW,
  parameter int ACCW = mm_pkg::MM_ACCW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [OPW-1:0]  a_edge [N],
  input  logic signed [OPW-1:0]  b_edge [N],
  output logic signed [ACCW-1:0] acc [N*N]
);

  // horizontal hop registers after columns 0..N-2, vertical after rows 0..N-2
  logic signed [OPW-1:0] a_hop [N][N-1];
  logic signed [OPW-1:0] b_hop [N-1][N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [OPW-1:0] a_here;
      logic signed [OPW-1:0] b_here;

      if (c == 0) begin : g_a_edge
        assign a_here = a_edge[r];
      end else begin : g_a_link
        assign a_here = a_hop[r][c-1];
      end

      if (r == 0) begin : g_b_edge
        assign b_here = b_edge[c];
      end else begin : g_b_link
        assign b_here = b_hop[r-1][c];
      end

      if (c < N - 1) begin : g_a_reg
        always_ff @(posedge clk) begin
          if (rst || clr) begin
            a_hop[r][c] <= '0;
          end else if (en) begin
            a_hop[r][c] <= a_here;
          end
        end
      end

      if (r < N - 1) begin : g_b_reg
        always_ff @(posedge clk) begin
          if (rst || clr) begin
            b_hop[r][c] <= '0;
          end else if (en) begin
            b_hop[r][c] <= b_here;
          end
        end
      end

      mm_cell #(
        .OPW  (OPW),
        .ACCW (ACCW)
      ) u_cell (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .en   (en),
        .a_in (a_here),
        .b_in (b_here),
        .acc  (acc[r*N+c])
      );
    end
  end

endmodule

// File: rtl/mm_top.sv
module mm_top #(
  parameter int N    = mm_pkg::MM_DIM,
  parameter int OPW  = mm_pkg::MM_OPW,
  parameter int ACCW = mm_pkg::MM_ACCW,
  localparam int IW  = $clog2(N * N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   a_wr_en,
  input  logic [IW-1:0]          a_wr_addr,
  input  logic signed [OPW-1:0]  a_wr_data,
  input  logic                   b_wr_en,
  input  logic [IW-1:0]          b_wr_addr,
  input  logic signed [OPW-1:0]  b_wr_data,
  input  logic [IW-1:0]          rd_addr,
  output logic                   busy,
  output logic                   done,
  output logic signed [ACCW-1:0] rd_data
);

  localparam int CW = $clog2(mm_pkg::run_cycles(N));

  logic                   clr;
  logic                   run;
  logic [CW-1:0]          step;
  logic signed [OPW-1:0]  abuf   [N*N];
  logic signed [OPW-1:0]  bbuf   [N*N];
  logic signed [OPW-1:0]  a_edge [N];
  logic signed [OPW-1:0]  b_edge [N];
  logic signed [ACCW-1:0] acc    [N*N];

  assign busy = run;

  mm_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .clr   (clr),
    .run   (run),
    .step  (step),
    .done  (done)
  );

  mm_opbuf #(.N(N), .OPW(OPW)) u_abuf (
    .clk     (clk),
    .wr_en   (a_wr_en && !run),
    .wr_addr (a_wr_addr),
    .wr_data (a_wr_data),
    .mem     (abuf)
  );

  mm_opbuf #(.N(N), .OPW(OPW)) u_bbuf (
    .clk     (clk),
    .wr_en   (b_wr_en && !run),
    .wr_addr (b_wr_addr),
    .wr_data (b_wr_data),
    .mem     (bbuf)
  );

  mm_skew #(.N(N), .OPW(OPW), .CW(CW)) u_skew (
    .run    (run),
    .step   (step),
    .abuf   (abuf),
    .bbuf   (bbuf),
    .a_edge (a_edge),
    .b_edge (b_edge)
  );

  mm_grid #(.N(N), .OPW(OPW), .ACCW(ACCW)) u_grid (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .en     (run),
    .a_edge (a_edge),
    .b_edge (b_edge),
    .acc    (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= acc[rd_addr];
    end
  end

endmodule

// File: rtl/mm_check.sv
module mm_check #(
  parameter int N = mm_pkg::MM_DIM
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done
);

  localparam int RUN = mm_pkg::run_cycles(N);

  int busy_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_len <= 0;
    end else if (busy) begin
      busy_len <= busy_len + 1;
    end else begin
      busy_len <= 0;
    end
  end

  assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_start_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_run_length_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == RUN));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_start_drops_done_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !done);

endmodule

bind mm_top mm_check #(.N(N)) u_mm_check (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/mm_top_bench.sv
module mm_top_bench;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic              a_wr_en;
  logic [3:0]        a_wr_addr;
  logic signed [7:0] a_wr_data;
  logic              b_wr_en;
  logic [3:0]        b_wr_addr;
  logic signed [7:0] b_wr_data;
  logic [3:0]        rd_addr;
  logic              busy;
  logic              done;
  logic signed [19:0] rd_data;

  always #4 clk = ~clk;

  mm_top u_mm_top (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .a_wr_en   (a_wr_en),
    .a_wr_addr (a_wr_addr),
    .a_wr_data (a_wr_data),
    .b_wr_en   (b_wr_en),
    .b_wr_addr (b_wr_addr),
    .b_wr_data (b_wr_data),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    ea [4][4];
  int    eb [4][4];
  int    exp_q [$];
  string cur_req = "R1";
  logic  rd_req = 1'b0;
  logic  mon_req;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // scoreboard monitor: rd_data registered one edge after rd_addr sampled (R6)
  always @(posedge clk) begin
    mon_req = rd_req;
    #2;
    if (mon_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, int'(rd_data), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(rd_data) == e, cur_req, int'(rd_data), e);
      end
    end
  end

  // driver: loads both stores from ea/eb (R2)
  task automatic load_mats();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        a_wr_en   = 1'b1;
        a_wr_addr = 4'(r * 4 + c);
        a_wr_data = 8'(ea[r][c]);
        b_wr_en   = 1'b1;
        b_wr_addr = 4'(r * 4 + c);
        b_wr_data = 8'(eb[r][c]);
      end
    end
    @(negedge clk);
    a_wr_en = 1'b0;
    b_wr_en = 1'b0;
  endtask

  // driver: computes the expected product and pushes it while requesting reads
  task automatic read_all(input string req, input bit zero);
    cur_req = req;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        int s;
        s = 0;
        if (!zero) begin
          for (int k = 0; k < 4; k++) s += ea[r][k] * eb[k][c];
        end
        @(negedge clk);
        exp_q.push_back(s);
        rd_addr = 4'(r * 4 + c);
        rd_req  = 1'b1;
      end
    end
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // start a run and check the busy/done timeline; optionally disturb it
  task automatic run_mat(input bit disturb);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3", int'(busy), 1);
    chk(done == 1'b0, "R7", int'(done), 0);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R4", int'(busy), 1);
      if (disturb && k == 3) begin
        start     = 1'b1;   // R8: ignored while busy
        a_wr_en   = 1'b1;   // R9: ignored while busy
        a_wr_addr = 4'd0;
        a_wr_data = 8'sd99;
        b_wr_en   = 1'b1;
        b_wr_addr = 4'd5;
        b_wr_data = -8'sd77;
      end else begin
        start   = 1'b0;
        a_wr_en = 1'b0;
        b_wr_en = 1'b0;
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, disturb ? "R8" : "R4", int'(busy), 0);
    chk(done == 1'b1, "R4", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    a_wr_en = 1'b0; a_wr_addr = '0; a_wr_data = '0;
    b_wr_en = 1'b0; b_wr_addr = '0; b_wr_data = '0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    read_all("R1", 1'b1);

    // set 1: distinct A times identity, R2 placement and R6 addressing
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        ea[r][c] = r * 4 + c + 1;
        eb[r][c] = (r == c) ? 1 : 0;
      end
    load_mats();
    run_mat(1'b0);
    read_all("R2", 1'b0);

    // set 2: signed mixed values, R5
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        ea[r][c] = ((r * 37 + c * 11 + 3) % 256) - 128;
        eb[r][c] = ((r * 53 + c * 29 + 7) % 200) - 100;
      end
    load_mats();
    run_mat(1'b0);
    read_all("R5", 1'b0);

    // R7: done holds while idle
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done == 1'b1, "R7", int'(done), 1);
    end

    // R8/R9: start and writes during the run have no effect
    run_mat(1'b1);
    read_all("R9", 1'b0);

    // R10: rerun without reloading
    run_mat(1'b0);
    read_all("R10", 1'b0);

    // R11: extremes
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        ea[r][c] = -128;
        eb[r][c] = -128;
      end
    load_mats();
    run_mat(1'b0);
    read_all("R11", 1'b0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) ea[r][c] = 127;
    load_mats();
    run_mat(1'b0);
    read_all("R11", 1'b0);

    finish_run();
  end

endmodule